// File: doc/BRIEF.md
# LPC Bus Read Target

This block is a target on a Low Pin Count bus. It follows the host's 4-bit LAD nibble stream and the active-low frame strobe, recognises two kinds of read cycle, and hands each decoded address to a simple back-end. The back-end answers through a request/acknowledge handshake with one data byte. The block then returns that byte to the host. It gives up ownership of LAD during the turnaround, inserts long-wait SYNC clocks until the back-end responds, signals ready SYNC, drives the byte as two nibbles and finally hands LAD back to the host.

Two static strap inputs control what the block answers. Firmware reads with a one-byte size are always eligible. Plain memory reads are answered only when the memory-read strap is set. A global read strap silences the target completely. A frame strobe seen low at any time abandons the running cycle and restarts decoding. Reset does the same.

The controller is one enumerated state machine. ST_IDLE waits for a frame. A start code of 0xD moves it to ST_FW_SEL, which checks the device-select nibble. A start code of 0x0 moves it to ST_MEM_TYPE, which checks the cycle-type nibble. A match in either state moves on to ST_ADDR, which collects address nibbles. A firmware read then passes through ST_SIZE. A memory read goes straight to the first turnaround, ST_TAR1, where the request pulse is issued. The machine then steps to ST_TAR2 and on to ST_WAIT, where it stays until the back-end acknowledges. On acknowledge it moves to ST_READY and then through ST_DLO, ST_DHI and ST_TAR_F back to ST_IDLE. Any mismatch goes back to ST_IDLE. So does a low read strap, from any state. A low frame strobe sends any state to a decode state or to ST_IDLE.

Top module: `lpc_rd_target`

## Requirements
- R1: While `rd_en` is 0 the target never drives LAD (`lad_oe` stays 0). Dropping `rd_en` during a cycle releases LAD on the next clock and abandons the cycle.
- R2: A firmware read is accepted and requested when all of the following hold, each on its own clock:
  - `frame_n` is low with LAD = 0xD.
  - Then LAD equals `dev_sel`.
  - Then seven address nibbles arrive, most significant first.
  - Then the size nibble is 0x0.
  The presented `req_addr` is the 28-bit address zero-extended to 32 bits.
- R3: A memory read is recognised when `frame_n` is low with LAD = 0x0, then the type nibble is 0x4, then eight address nibbles arrive, most significant first. It is answered only when `memrd_en` is 1. `req_addr` is the full 32-bit address. With `memrd_en` 0, or with any other type nibble, the target stays silent.
- R4: A firmware read with a size nibble other than 0x0, or with a device-select nibble different from `dev_sel`, produces no request and no LAD drive, and the target returns to idle.
- R5: `req` is high for exactly one clock, in the first turnaround clock, with `req_addr` valid. LAD is not driven in either turnaround clock.
- R6: Starting on the clock after the second turnaround, the target drives SYNC 0x6 with `lad_oe` high. It repeats this every clock while `ack` is low, and always does so for at least one clock.
- R7: On a long-wait clock where `ack` is 1, `ack_data` is captured. The next four clocks drive SYNC 0x0, then `ack_data[3:0]`, then `ack_data[7:4]`, then 0xF, all with `lad_oe` high. LAD is released on the clock after that.
- R8: `frame_n` sampled low at any point releases LAD on the next clock and restarts decoding from the start code seen with it.
- R9: While `rst_n` is low, `lad_oe` and `req` are 0, and the target is idle once reset ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Strap: 1 allows any read response |
| memrd_en | input | 1 | Strap: 1 also answers plain memory reads |
| dev_sel | input | 4 | Device-select value matched in firmware reads |
| frame_n | input | 1 | Active-low frame strobe from the host |
| lad_in | input | 4 | LAD nibble as seen on the bus |
| lad_out | output | 4 | Nibble the target drives onto LAD |
| lad_oe | output | 1 | LAD output enable |
| req | output | 1 | One-clock request to the back-end |
| req_addr | output | 32 | Address presented with the request |
| ack | input | 1 | Back-end acknowledge, data valid |
| ack_data | input | 8 | Byte returned by the back-end |

## Verification
Some properties are checked on every cycle by the bound checker:
- LAD is released on the clock after a low frame strobe or a low read strap.
- The request lasts a single clock, and LAD stays quiet across both turnaround clocks around it.
- Every drive period opens with a long-wait SYNC.
- Reset holds the outputs quiet.

Other behaviour only the bench's sweeps can show, because it depends on what the host sent and what the back-end returned:
- The decoded address.
- Which start/type/select/size combinations are accepted.
- The exact number of long-wait clocks.
- The order of the data nibbles.
- Decoding restarting after an abort.

// File: rtl/lpcr_pkg.sv
package lpcr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FW_SEL,
        ST_MEM_TYPE,
        ST_ADDR,
        ST_SIZE,
        ST_TAR1,
        ST_TAR2,
        ST_WAIT,
        ST_READY,
        ST_DLO,
        ST_DHI,
        ST_TAR_F
    } lpcr_state_e;

    typedef enum logic [1:0] {
        KIND_NONE,
        KIND_FW,
        KIND_MEM
    } lpcr_kind_e;

    typedef enum logic [2:0] {
        DRV_NONE,
        DRV_LONG,
        DRV_OK,
        DRV_LO,
        DRV_HI,
        DRV_END
    } lpcr_drv_e;

    localparam logic [3:0] START_FW   = 4'hD;
    localparam logic [3:0] START_MEM  = 4'h0;
    localparam logic [3:0] TYPE_MEMRD = 4'h4;
    localparam logic [3:0] SIZE_ONE   = 4'h0;
    localparam logic [3:0] SYNC_LONG  = 4'h6;
    localparam logic [3:0] SYNC_READY = 4'h0;
    localparam logic [3:0] NIB_IDLE   = 4'hF;

endpackage

// File: rtl/lpcr_start_decode.sv
module lpcr_start_decode
    import lpcr_pkg::*;
(
    input  logic       rd_en,
    input  logic [3:0] nib,
    output lpcr_kind_e kind
);

    always_comb begin
        kind = KIND_NONE;
        if (rd_en) begin
            if (nib == START_FW) begin
                kind = KIND_FW;
            end else if (nib == START_MEM) begin
                kind = KIND_MEM;
            end
        end
    end

endmodule

// File: rtl/lpcr_addr_shift.sv
module lpcr_addr_shift #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift,
    input  logic [3:0]        nib,
    output logic [ADDR_W-1:0] addr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (clr) begin
            addr <= '0;
        end else if (shift) begin
            addr <= {addr[ADDR_W-5:0], nib};
        end
    end

endmodule

// File: rtl/lpcr_data_out.sv
module lpcr_data_out
    import lpcr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] din,
    input  lpcr_drv_e  sel,
    output logic [3:0] nib_out
);

    logic [7:0] byte_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_q <= '0;
        end else if (load) begin
            byte_q <= din;
        end
    end

    always_comb begin
        unique case (sel)
            DRV_LONG: nib_out = SYNC_LONG;
            DRV_OK:   nib_out = SYNC_READY;
            DRV_LO:   nib_out = byte_q[3:0];
            DRV_HI:   nib_out = byte_q[7:4];
            default:  nib_out = NIB_IDLE;
        endcase
    end

endmodule

// File: rtl/lpc_rd_target.sv
module lpc_rd_target
    import lpcr_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int FW_NIBS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              memrd_en,
    input  logic [3:0]        dev_sel,
    input  logic              frame_n,
    input  logic [3:0]        lad_in,
    output logic [3:0]        lad_out,
    output logic              lad_oe,
    output logic              req,
    output logic [ADDR_W-1:0] req_addr,
    input  logic              ack,
    input  logic [7:0]        ack_data
);

    localparam int MEM_NIBS = ADDR_W / 4;
    localparam int CNT_W    = $clog2(MEM_NIBS + 1);
    localparam logic [CNT_W-1:0] FW_LAST  = CNT_W'(FW_NIBS - 1);
    localparam logic [CNT_W-1:0] MEM_LAST = CNT_W'(MEM_NIBS - 1);

    lpcr_state_e      state_q, state_d;
    lpcr_kind_e       start_kind;
    lpcr_drv_e        drv_sel;
    logic [CNT_W-1:0] nib_cnt_q;
    logic             is_fw_q;
    logic             addr_last;
    logic             addr_clr;
    logic             addr_shift;
    logic             byte_load;

    lpcr_start_decode u_dec (
        .rd_en (rd_en),
        .nib   (lad_in),
        .kind  (start_kind)
    );

    lpcr_addr_shift #(.ADDR_W(ADDR_W)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (addr_clr),
        .shift (addr_shift),
        .nib   (lad_in),
        .addr  (req_addr)
    );

    lpcr_data_out u_dout (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (byte_load),
        .din     (ack_data),
        .sel     (drv_sel),
        .nib_out (lad_out)
    );

    assign addr_last  = (nib_cnt_q == (is_fw_q ? FW_LAST : MEM_LAST));
    assign addr_clr   = !frame_n;
    assign addr_shift = (state_q == ST_ADDR) && frame_n && rd_en;

    // State register plus the nibble counter and the cycle-kind flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            nib_cnt_q <= '0;
            is_fw_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (addr_shift) begin
                nib_cnt_q <= nib_cnt_q + 1'b1;
            end else begin
                nib_cnt_q <= '0;
            end
            if (!frame_n) begin
                is_fw_q <= (start_kind == KIND_FW);
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!rd_en) begin
            state_d = ST_IDLE;
        end else if (!frame_n) begin
            unique case (start_kind)
                KIND_FW:  state_d = ST_FW_SEL;
                KIND_MEM: state_d = ST_MEM_TYPE;
                default:  state_d = ST_IDLE;
            endcase
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_FW_SEL:   state_d = (lad_in == dev_sel) ? ST_ADDR : ST_IDLE;
                ST_MEM_TYPE: state_d = (lad_in == TYPE_MEMRD && memrd_en) ? ST_ADDR : ST_IDLE;
                ST_ADDR: begin
                    if (addr_last) begin
                        state_d = is_fw_q ? ST_SIZE : ST_TAR1;
                    end
                end
                ST_SIZE:     state_d = (lad_in == SIZE_ONE) ? ST_TAR1 : ST_IDLE;
                ST_TAR1:     state_d = ST_TAR2;
                ST_TAR2:     state_d = ST_WAIT;
                ST_WAIT:     state_d = ack ? ST_READY : ST_WAIT;
                ST_READY:    state_d = ST_DLO;
                ST_DLO:      state_d = ST_DHI;
                ST_DHI:      state_d = ST_TAR_F;
                ST_TAR_F:    state_d = ST_IDLE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // Output logic
    always_comb begin
        req       = 1'b0;
        lad_oe    = 1'b0;
        drv_sel   = DRV_NONE;
        byte_load = 1'b0;
        unique case (state_q)
            ST_TAR1: req = 1'b1;
            ST_WAIT: begin
                lad_oe    = 1'b1;
                drv_sel   = DRV_LONG;
                byte_load = ack;
            end
            ST_READY: begin
                lad_oe  = 1'b1;
                drv_sel = DRV_OK;
            end
            ST_DLO: begin
                lad_oe  = 1'b1;
                drv_sel = DRV_LO;
            end
            ST_DHI: begin
                lad_oe  = 1'b1;
                drv_sel = DRV_HI;
            end
            ST_TAR_F: begin
                lad_oe  = 1'b1;
                drv_sel = DRV_END;
            end
            default: begin
                req = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lpcr_checker.sv
module lpcr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_en,
    input logic       frame_n,
    input logic [3:0] lad_out,
    input logic       lad_oe,
    input logic       req
);

    // R1: a low read strap leaves LAD released on the following clock
    a_r1_strap_silences: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rd_en) |-> !lad_oe);

    // R8: a low frame strobe leaves LAD released on the following clock
    a_r8_frame_abort: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!frame_n) |-> !lad_oe);

    // R5: the request lasts a single clock
    a_r5_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);

    // R5: LAD quiet in the first turnaround clock
    a_r5_tar1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> !lad_oe);

    // R5: LAD quiet in the second turnaround clock
    a_r5_tar2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !lad_oe);

    // R6: every drive period opens with a long-wait SYNC
    a_r6_first_long_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lad_oe) |-> (lad_out == 4'h6));

    // R9: outputs quiet during reset
    a_r9_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (!lad_oe && !req));

endmodule

bind lpc_rd_target lpcr_checker u_lpcr_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .frame_n (frame_n),
    .lad_out (lad_out),
    .lad_oe  (lad_oe),
    .req     (req)
);

// File: tb/tb_lpc_rd_target.sv
module tb_lpc_rd_target;

    localparam logic [3:0] MY_SEL = 4'h5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b1;
    logic        memrd_en = 1'b1;
    logic [3:0]  dev_sel = MY_SEL;
    logic        frame_n = 1'b1;
    logic [3:0]  lad_in = 4'hF;
    logic [3:0]  lad_out;
    logic        lad_oe;
    logic        req;
    logic [31:0] req_addr;
    logic        ack = 1'b0;
    logic [7:0]  ack_data = 8'h00;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit req_seen = 1'b0;
    bit oe_seen = 1'b0;

    always #2 clk = ~clk;

    lpc_rd_target dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .memrd_en (memrd_en),
        .dev_sel  (dev_sel),
        .frame_n  (frame_n),
        .lad_in   (lad_in),
        .lad_out  (lad_out),
        .lad_oe   (lad_oe),
        .req      (req),
        .req_addr (req_addr),
        .ack      (ack),
        .ack_data (ack_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        if (req) req_seen = 1'b1;
        if (lad_oe) oe_seen = 1'b1;
    endtask

    // Host side up to the first turnaround clock
    task automatic send_header(input bit fw, input logic [3:0] second, input logic [3:0] size,
                               input logic [31:0] addr);
        frame_n = 1'b0;
        lad_in  = fw ? 4'hD : 4'h0;
        tick();
        chk(!lad_oe, "R8", 32'(lad_oe), 0);
        frame_n = 1'b1;
        lad_in  = second;
        tick();
        for (int i = 0; i < (fw ? 7 : 8); i++) begin
            lad_in = addr[((fw ? 7 : 8) - 1 - i) * 4 +: 4];
            tick();
        end
        if (fw) begin
            lad_in = size;
            tick();
        end
        lad_in = 4'hF;
    endtask

    task automatic do_read(input bit fw, input logic [3:0] second, input logic [3:0] size,
                           input logic [31:0] addr, input int waits, input logic [7:0] data,
                           input bit expect_ok, input string tag);
        logic [31:0] exp_addr;
        req_seen = 1'b0;
        oe_seen  = 1'b0;
        exp_addr = fw ? {4'h0, addr[27:0]} : addr;
        send_header(fw, second, size, addr);
        if (!expect_ok) begin
            for (int i = 0; i < 6; i++) tick();
            chk(!req_seen, tag, 32'(req_seen), 0);
            chk(!oe_seen, tag, 32'(oe_seen), 0);
            return;
        end
        chk(req == 1'b1, "R5", 32'(req), 1);
        chk(req_addr == exp_addr, tag, req_addr, exp_addr);
        chk(!lad_oe, "R5", 32'(lad_oe), 0);
        tick();
        chk(!req && !lad_oe, "R5", {30'b0, req, lad_oe}, 0);
        tick();
        chk(lad_oe && lad_out == 4'h6, "R6", {27'b0, lad_oe, lad_out}, 32'h16);
        for (int w = 0; w < waits; w++) begin
            tick();
            chk(lad_oe && lad_out == 4'h6, "R6", {27'b0, lad_oe, lad_out}, 32'h16);
        end
        ack      = 1'b1;
        ack_data = data;
        tick();
        ack      = 1'b0;
        ack_data = 8'h00;
        chk(lad_oe && lad_out == 4'h0, "R7", {27'b0, lad_oe, lad_out}, 32'h10);
        tick();
        chk(lad_oe && lad_out == data[3:0], "R7", {27'b0, lad_oe, lad_out}, {27'b0, 1'b1, data[3:0]});
        tick();
        chk(lad_oe && lad_out == data[7:4], "R7", {27'b0, lad_oe, lad_out}, {27'b0, 1'b1, data[7:4]});
        tick();
        chk(lad_oe && lad_out == 4'hF, "R7", {27'b0, lad_oe, lad_out}, 32'h1F);
        tick();
        chk(!lad_oe, "R7", 32'(lad_oe), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(!lad_oe && !req, "R9", {30'b0, lad_oe, req}, 0);
        rst_n = 1'b1;
        tick();
        chk(!lad_oe && !req, "R9", {30'b0, lad_oe, req}, 0);

        // R2 and R4: firmware reads over select, size and wait count
        for (int sz = 0; sz < 3; sz++) begin
            for (int m = 0; m < 2; m++) begin
                for (int w = 0; w < 3; w++) begin
                    logic [31:0] a;
                    a = 32'h1234_5678 ^ (32'(sz * 6 + m * 3 + w) * 32'h9E37_79B9);
                    do_read(1'b1, m ? MY_SEL : 4'hA, 4'(sz), a, w, 8'(8'h3C + sz * 37 + w * 11),
                            (m == 1) && (sz == 0), (m == 1 && sz == 0) ? "R2" : "R4");
                end
            end
        end

        // R3: memory reads over the strap and type nibble
        for (int en = 0; en < 2; en++) begin
            for (int t = 0; t < 2; t++) begin
                for (int w = 0; w < 2; w++) begin
                    memrd_en = en[0];
                    do_read(1'b0, t ? 4'h4 : 4'h2, 4'h0, 32'hA5C3_0F96 + 32'(en * 4 + t * 2 + w) * 32'h0101_0111,
                            w * 4, 8'(8'hD2 ^ (t * 8'h55) ^ w), (en == 1) && (t == 1), "R3");
                end
            end
        end
        memrd_en = 1'b1;

        // R8: abort in the long wait, then a fresh read decodes normally
        send_header(1'b1, MY_SEL, 4'h0, 32'h0ABC_DEF1);
        tick();
        tick();
        chk(lad_oe && lad_out == 4'h6, "R6", {27'b0, lad_oe, lad_out}, 32'h16);
        frame_n = 1'b0;
        lad_in  = 4'hD;
        tick();
        chk(!lad_oe && !req, "R8", {30'b0, lad_oe, req}, 0);
        do_read(1'b1, MY_SEL, 4'h0, 32'h0765_4321, 1, 8'h9A, 1'b1, "R8");

        // R8: abort in the address phase with a memory start code
        frame_n = 1'b0;
        lad_in  = 4'hD;
        tick();
        frame_n = 1'b1;
        lad_in  = MY_SEL;
        tick();
        lad_in = 4'h3;
        tick();
        do_read(1'b0, 4'h4, 4'h0, 32'hFEDC_BA98, 0, 8'h71, 1'b1, "R8");

        // R1: strap low blocks a valid read
        rd_en = 1'b0;
        do_read(1'b1, MY_SEL, 4'h0, 32'h0111_2222, 0, 8'h00, 1'b0, "R1");
        rd_en = 1'b1;

        // R1: strap dropped in the long wait releases LAD and ends the cycle
        send_header(1'b1, MY_SEL, 4'h0, 32'h0333_4444);
        tick();
        tick();
        chk(lad_oe, "R6", 32'(lad_oe), 1);
        rd_en = 1'b0;
        tick();
        chk(!lad_oe, "R1", 32'(lad_oe), 0);
        rd_en = 1'b1;
        oe_seen = 1'b0;
        ack = 1'b1;
        for (int i = 0; i < 4; i++) tick();
        ack = 1'b0;
        chk(!oe_seen, "R1", 32'(oe_seen), 0);

        // R9: reset in mid-cycle releases LAD at once
        send_header(1'b0, 4'h4, 4'h0, 32'h5555_AAAA);
        tick();
        tick();
        rst_n = 1'b0;
        #1;
        chk(!lad_oe && !req, "R9", {30'b0, lad_oe, req}, 0);
        tick();
        rst_n = 1'b1;
        oe_seen = 1'b0;
        for (int i = 0; i < 3; i++) tick();
        chk(!oe_seen, "R9", 32'(oe_seen), 0);
        do_read(1'b1, MY_SEL, 4'h0, 32'h0246_8ACE, 2, 8'hE4, 1'b1, "R9");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule